// File: doc/BRIEF.md
# Interleaved Four-Bank Word Memory

This block is a byte-addressed, word-aligned data store with 16-bit words, split into four banks that are interleaved on word address. Every cycle the requester may present one read or one write. Address bits [2:1] choose the bank and the bits above them choose the word inside that bank. Once a bank takes a request it stays occupied for a fixed window. During that window any other bank may still take a request on the very next cycle.

Flow control is a ready/valid handshake expressed through plain pins. A request is offered by raising `rd_i` or `wr_i` and counts as taken in any cycle where `stall_o` and `err_o` are both low. `stall_o` is the inverse of ready. It is combinational with the request, so the requester keeps its request up and tries again in the next cycle. Read data comes back with `rvalid_o` and has no back-pressure: the requester must take it in the cycle it appears. A refused or faulty request changes nothing. After reset the storage holds zeros.

The address width is a parameter. Its default of 11 bits gives 2 KB, which keeps elaboration small. Setting it to 16 gives the full 64 KB.

Top module: `banked_word_mem`

## Requirements
- R1: The bank is address bits [2:1] and the word inside the bank is the bits above bit 2. Writes to four consecutive word addresses land in four different banks, and each word reads back unchanged.
- R2: A read taken at edge N drives `rvalid_o` high with the addressed word on `rdata_o` for exactly one cycle, the cycle after edge N+1.
- R3: A write taken at edge N is committed at edge N+3. A read of the same word taken at edge N+4, the earliest one the bank allows, returns the new data.
- R4: `busy_o[b]` is high in the three cycles after bank b takes a request and low from the fourth cycle on.
- R5: A request whose bank has its `busy_o` bit set raises `stall_o` in that same cycle and has no effect. A request to a bank that is not busy is taken even in the cycle right after another bank took one.
- R6: `err_o` rises in the same cycle when a request has address bit 0 set or has `rd_i` and `wr_i` both high. Such a request has no effect, and `stall_o` stays low while `err_o` is high.
- R7: Synchronous active-high reset clears all busy state, drops in-flight reads and writes, holds `rvalid_o` low and sets every stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| addr_i | input | ADDR_W | Byte address, bit 0 must be zero |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, qualified by rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle per read |
| stall_o | output | 1 | Request refused because its bank is busy |
| busy_o | output | 4 | Per-bank occupancy, bit b for bank b |
| err_o | output | 1 | Unaligned or read-and-write request |

## Verification
A busy counter that is wrong shows up on `busy_o` in the very next cycle. A stall that arrives one cycle too early or too late also shows on `stall_o` in the request cycle, and the bench probes the exact end of the window with back-to-back retries. A slot in the read or write schedule that is wrong only shows on `rdata_o` two cycles after the read that exposes it, so every write is read back at the earliest legal cycle. Stalled and faulty writes are aimed at words that are read later, which makes a leaked write visible there.

// File: rtl/bmem_pkg.sv
package bmem_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/bmem_decode.sv
module bmem_decode
  import bmem_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 2,
  localparam int WORD_W = ADDR_W - BANK_W - 1
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              req_o,
  output logic              err_o,
  output op_e               op_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [WORD_W-1:0] word_o
);
  assign req_o  = rd_i | wr_i;
  assign err_o  = req_o & (addr_i[0] | (rd_i & wr_i));
  assign op_o   = rd_i ? OP_RD : OP_WR;
  assign bank_o = addr_i[BANK_W:1];
  assign word_o = addr_i[ADDR_W-1:BANK_W+1];
endmodule

// File: rtl/bmem_bank.sv
module bmem_bank
  import bmem_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 4,
  parameter int RD_LAT   = 2,
  parameter int WR_LAT   = 4,
  localparam int DEPTH   = 1 << WORD_W,
  localparam int CNT_W   = $clog2(BUSY_CYC + 1),
  localparam int RD_SLOT = BUSY_CYC - RD_LAT + 1,
  localparam int WR_SLOT = BUSY_CYC - WR_LAT + 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              acc_i,
  input  op_e               op_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              rv_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [CNT_W-1:0]  cnt_q;
  op_e               op_q;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              rd_fire, wr_fire;

  assign busy_o  = (cnt_q != '0);
  assign rd_fire = (op_q == OP_RD) && (cnt_q == CNT_W'(RD_SLOT));
  assign wr_fire = (op_q == OP_WR) && (cnt_q == CNT_W'(WR_SLOT));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q   <= '0;
      op_q    <= OP_NONE;
      word_q  <= '0;
      data_q  <= '0;
      rv_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      rv_o <= rd_fire;
      if (rd_fire) rdata_o <= mem_q[word_q];
      if (acc_i) begin
        cnt_q  <= CNT_W'(BUSY_CYC - 1);
        op_q   <= op_i;
        word_q <= word_i;
        data_q <= wdata_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_fire) begin
      mem_q[word_q] <= data_q;
    end
  end

  // R4
  accept_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_i |-> (cnt_q == '0));

  // R2
  read_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rv_o |-> ($past(op_q) == OP_RD));
endmodule

// File: rtl/banked_word_mem.sv
module banked_word_mem
  import bmem_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 16,
  parameter int BUSY_CYC = 4,
  parameter int RD_LAT   = 2,
  parameter int WR_LAT   = 4,
  localparam int NBANK   = 4,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int WORD_W  = ADDR_W - BANK_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              stall_o,
  output logic [NBANK-1:0]  busy_o,
  output logic              err_o
);
  logic              req;
  op_e               op;
  logic [BANK_W-1:0] bank;
  logic [WORD_W-1:0] word;
  logic              acc;
  logic [NBANK-1:0]  acc_vec, rv_vec;
  logic [DATA_W-1:0] bank_rdata [NBANK];

  bmem_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_dec (
    .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i),
    .req_o(req), .err_o(err_o), .op_o(op), .bank_o(bank), .word_o(word)
  );

  assign stall_o = req & ~err_o & busy_o[bank];
  assign acc     = req & ~err_o & ~busy_o[bank];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign acc_vec[b] = acc && (bank == BANK_W'(b));
    bmem_bank #(
      .WORD_W(WORD_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC),
      .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
    ) i_bank (
      .clk_i(clk_i), .rst_i(rst_i), .acc_i(acc_vec[b]), .op_i(op),
      .word_i(word), .wdata_i(wdata_i), .busy_o(busy_o[b]),
      .rv_o(rv_vec[b]), .rdata_o(bank_rdata[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++)
      if (rv_vec[b]) rdata_o = rdata_o | bank_rdata[b];
  end
  assign rvalid_o = |rv_vec;

  // R5
  stall_blocks_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    stall_o |-> (acc_vec == '0));

  // R6
  err_not_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(err_o && stall_o));

  // R4
  busy_set_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acc |=> busy_o[$past(bank)]);

  // R2
  one_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(rv_vec));
endmodule

// File: tb/test_banked_word_mem.sv
module test_banked_word_mem;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int NV = 36;

  logic          clk = 1'b0;
  logic          rst, rd, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid, stall, err;
  logic [3:0]    busy;
  int            n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  banked_word_mem i_banked_word_mem (
    .clk_i(clk), .rst_i(rst), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .stall_o(stall),
    .busy_o(busy), .err_o(err)
  );

  // {rd, wr, addr, wdata, exp_stall, exp_err, exp_busy, read_due, read_data}
  localparam logic [51:0] VEC [NV] = '{
    {1'b0,1'b1,11'h010,16'hA1A1,1'b0,1'b0,4'b0000,1'b0,16'h0000},
    {1'b0,1'b1,11'h012,16'hB2B2,1'b0,1'b0,4'b0001,1'b0,16'h0000},
    {1'b0,1'b1,11'h014,16'hC3C3,1'b0,1'b0,4'b0011,1'b0,16'h0000},
    {1'b0,1'b1,11'h016,16'hD4D4,1'b0,1'b0,4'b0111,1'b0,16'h0000},
    {1'b1,1'b0,11'h010,16'h0000,1'b0,1'b0,4'b1110,1'b1,16'hA1A1},
    {1'b1,1'b0,11'h018,16'h0000,1'b1,1'b0,4'b1101,1'b0,16'h0000},
    {1'b1,1'b0,11'h012,16'h0000,1'b0,1'b0,4'b1001,1'b1,16'hB2B2},
    {1'b0,1'b1,11'h011,16'hEEEE,1'b0,1'b1,4'b0011,1'b0,16'h0000},
    {1'b0,1'b1,11'h01C,16'h5555,1'b0,1'b0,4'b0010,1'b0,16'h0000},
    {1'b1,1'b1,11'h016,16'h0000,1'b0,1'b1,4'b0110,1'b0,16'h0000},
    {1'b1,1'b0,11'h014,16'h0000,1'b1,1'b0,4'b0100,1'b0,16'h0000},
    {1'b1,1'b0,11'h014,16'h0000,1'b1,1'b0,4'b0100,1'b0,16'h0000},
    {1'b1,1'b0,11'h014,16'h0000,1'b0,1'b0,4'b0000,1'b1,16'hC3C3},
    {1'b1,1'b0,11'h01C,16'h0000,1'b1,1'b0,4'b0100,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0100,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0100,1'b0,16'h0000},
    {1'b1,1'b0,11'h01C,16'h0000,1'b0,1'b0,4'b0000,1'b1,16'h5555},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0100,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0100,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0100,1'b0,16'h0000},
    {1'b0,1'b1,11'h020,16'h7777,1'b0,1'b0,4'b0000,1'b0,16'h0000},
    {1'b0,1'b1,11'h020,16'hFFFF,1'b1,1'b0,4'b0001,1'b0,16'h0000},
    {1'b1,1'b0,11'h020,16'h0000,1'b1,1'b0,4'b0001,1'b0,16'h0000},
    {1'b1,1'b0,11'h020,16'h0000,1'b1,1'b0,4'b0001,1'b0,16'h0000},
    {1'b1,1'b0,11'h020,16'h0000,1'b0,1'b0,4'b0000,1'b1,16'h7777},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0001,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0001,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0001,1'b0,16'h0000},
    {1'b1,1'b0,11'h010,16'h0000,1'b0,1'b0,4'b0000,1'b1,16'hA1A1},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0001,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0001,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b0001,1'b0,16'h0000},
    {1'b1,1'b0,11'h016,16'h0000,1'b0,1'b0,4'b0000,1'b1,16'hD4D4},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b1000,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b1000,1'b0,16'h0000},
    {1'b0,1'b0,11'h000,16'h0000,1'b0,1'b0,4'b1000,1'b0,16'h0000}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    @(negedge clk);
    rd = r; wr = w; addr = a; wdata = d;
    #2;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 5000, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic       due1, due0;
    logic [15:0] dat1, dat0;
    rst = 1'b1; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    due1 = 1'b0; due0 = 1'b0; dat1 = '0; dat0 = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0; #2;
    // R7 reset state
    chk(busy == 4'b0000, "R7 busy after reset", busy, 0);
    chk(!rvalid && !stall && !err, "R7 outputs idle", {rvalid, stall, err}, 0);

    for (int k = 0; k < NV; k++) begin
      logic [51:0] v;
      v = VEC[k];
      drive(v[51], v[50], v[49:39], v[38:23]);
      // R5 stall, R6 err, R4 busy, R1 bank steering via busy bits
      chk(stall == v[22], $sformatf("R5 stall step %0d", k), stall, v[22]);
      chk(err == v[21], $sformatf("R6 err step %0d", k), err, v[21]);
      chk(busy == v[20:17], $sformatf("R4 busy step %0d", k), busy, v[20:17]);
      // R2 read return two cycles later, R3 write visibility, R1 word mapping
      chk(rvalid == due1, $sformatf("R2 rvalid step %0d", k), rvalid, due1);
      if (due1)
        chk(rdata == dat1, $sformatf("R3 R1 rdata step %0d", k), rdata, dat1);
      due1 = due0; dat1 = dat0;
      due0 = v[16]; dat0 = v[15:0];
    end

    // R7: reset drops an in-flight write and clears storage
    drive(1'b0, 1'b1, 11'h030, 16'h1234);
    @(negedge clk); rd = 1'b0; wr = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; #2;
    chk(busy == 4'b0000, "R7 busy cleared mid-flight", busy, 0);
    chk(rvalid == 1'b0, "R7 rvalid low after reset", rvalid, 0);
    drive(1'b1, 1'b0, 11'h030, 16'h0000);
    drive(1'b1, 1'b0, 11'h012, 16'h0000);
    drive(1'b0, 1'b0, 11'h000, 16'h0000);
    chk(rvalid && rdata == 16'h0000, "R7 pending write dropped", rdata, 0);
    drive(1'b0, 1'b0, 11'h000, 16'h0000);
    chk(rvalid && rdata == 16'h0000, "R7 storage zeroed", rdata, 0);
    drive(1'b0, 1'b0, 11'h000, 16'h0000);
    chk(!rvalid, "R2 rvalid one cycle only", rvalid, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule